// File: doc/BRIEF.md
# VFD Grid Scan and Dimming Controller

This block produces the time-multiplexed grid strobes and the segment-enable window for a vacuum fluorescent display of up to 24 grids. A slot counter runs at the master clock rate. Every grid owns one slot of 1024 clocks. The first 960 clocks of a slot form the active window and the last 64 clocks are always dark. Inside the active window the segment strobe stays high for a programmable number of clocks, and this sets the brightness.

Software-facing registers outside this block supply four settings: a 10-bit brightness value, the count of scanned digits, a two-bit light override and a grid routing map. The routing map gives every slot its own 24-bit set of grid lines, so neighbouring grids can be driven in parallel. The block outputs the grid enables, the index of the digit being shown (which addresses the character store) and the segment-enable strobe. Brightness and digit count are shadowed and only change at frame boundaries, so a frame never mixes two settings.

Top module: `vfd_scan_ctrl`

## Requirements
- R1: Each slot lasts 1024 clocks. `digit_o` holds the slot's digit index for the whole slot, and the index steps 0, 1, ... up to count-1, then returns to 0.
- R2: In the last 64 clocks of every slot (slot positions 960 to 1023), `grid_o` is all zero and `seg_en_o` is low, whatever the settings.
- R3: With the override at 00, `seg_en_o` is high exactly at slot positions p < min(duty, 960). A duty of 0 keeps the segments dark, and any duty of 960 or more gives 960 lit clocks.
- R4: The digit count is taken from `digits_i`. A value of 0 acts as 1 and any value above 24 acts as 24. Digit indices at or above the count never appear, so a frame lasts count x 1024 clocks.
- R5: The override `light_i` works as follows: bit 0 = 1 (01 or 11) forces `seg_en_o` high for the whole active window, 10 forces it low, and 00 selects normal duty operation. The override takes priority over the duty value.
- R6: During the active window of the slot with digit index k, `grid_o` equals `grid_map_i[k*24 +: 24]`, with bit j driving grid line j. Any number of bits may be set.
- R7: Duty and digit count are captured during reset and at the clock edge that ends the final slot of a frame. Changes between those points have no effect until that edge. Changes to the override and the grid map show on the outputs one clock later.
- R8: The outputs are registered. The first rising edge with reset low presents slot position 0 of digit 0.
- R9: While the synchronous reset `rst` is high, `grid_o` is zero, `seg_en_o` is low and `digit_o` is 0 on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| duty_i | input | 10 | Lit clocks per slot (saturates at 960) |
| digits_i | input | 5 | Number of scanned digits (0 acts as 1, above 24 acts as 24) |
| light_i | input | 2 | Override: 00 normal, 10 all dark, x1 all lit |
| grid_map_i | input | 576 | Per-slot grid line set, 24 bits per slot |
| grid_o | output | 24 | Grid enables |
| digit_o | output | 5 | Digit index of the current slot |
| seg_en_o | output | 1 | Segment enable strobe |

## Verification
The case hardest to reach is a brightness or digit-count change that lands in the middle of a frame and must stay invisible until the last slot of that frame ends. With 24 digits, this takes more than 24,000 clocks of waiting after the write. The stimulus reaches this case in two ways. Short frames (one or two digits, often drawn by the random mix) bring many frame boundaries within the run time. A directed phase writes new values halfway through both a long frame and a short one. The bench model captures the settings at exactly the edge where the final slot of a frame ends, so a design that loads them early or late differs from the model at the first lit-clock count after the write.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

    // Override encoding on light_i
    typedef enum logic [1:0] {
        LIGHT_NORMAL   = 2'b00,
        LIGHT_ALL_ON   = 2'b01,
        LIGHT_ALL_OFF  = 2'b10,
        LIGHT_ALL_ON_B = 2'b11
    } light_mode_e;

    localparam int DEF_NUM_GRIDS  = 24;
    localparam int DEF_SLOT_CLKS  = 1024;
    localparam int DEF_BLANK_CLKS = 64;
    localparam int DEF_DUTY_W     = 10;

endpackage

// File: rtl/vfd_slot_timer.sv
module vfd_slot_timer #(
    parameter int NUM_GRIDS = vfd_scan_pkg::DEF_NUM_GRIDS,
    parameter int SLOT_CLKS = vfd_scan_pkg::DEF_SLOT_CLKS,
    localparam int SLOT_W   = $clog2(SLOT_CLKS),
    localparam int DIG_W    = $clog2(NUM_GRIDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIG_W-1:0]  digits_act,
    output logic [SLOT_W-1:0] cnt_o,
    output logic [DIG_W-1:0]  dig_o,
    output logic              frame_end_o
);

    typedef struct packed {
        logic [SLOT_W-1:0] cnt;
        logic [DIG_W-1:0]  dig;
    } tmr_t;

    tmr_t st_d, st_q;
    logic slot_end;
    logic last_dig;

    always_comb begin
        slot_end    = (st_q.cnt == SLOT_W'(SLOT_CLKS - 1));
        last_dig    = (st_q.dig == (digits_act - DIG_W'(1)));
        frame_end_o = slot_end && last_dig;

        st_d = st_q;
        if (rst) begin
            st_d.cnt = '0;
            st_d.dig = '0;
        end else if (slot_end) begin
            st_d.cnt = '0;
            st_d.dig = last_dig ? '0 : st_q.dig + DIG_W'(1);
        end else begin
            st_d.cnt = st_q.cnt + SLOT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign dig_o = st_q.dig;

endmodule

// File: rtl/vfd_cfg_shadow.sv
module vfd_cfg_shadow #(
    parameter int NUM_GRIDS = vfd_scan_pkg::DEF_NUM_GRIDS,
    parameter int SLOT_CLKS = vfd_scan_pkg::DEF_SLOT_CLKS,
    parameter int BLANK_CLKS = vfd_scan_pkg::DEF_BLANK_CLKS,
    parameter int DUTY_W    = vfd_scan_pkg::DEF_DUTY_W,
    localparam int DIG_W    = $clog2(NUM_GRIDS + 1),
    localparam int DUTY_MAX = SLOT_CLKS - BLANK_CLKS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [DIG_W-1:0]  digits_i,
    output logic [DUTY_W-1:0] duty_o,
    output logic [DIG_W-1:0]  digits_o
);

    typedef struct packed {
        logic [DUTY_W-1:0] duty;
        logic [DIG_W-1:0]  digits;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [DUTY_W-1:0] duty_clamped;
    logic [DIG_W-1:0]  digits_clamped;

    always_comb begin
        // saturate brightness to the active window length
        if (int'(duty_i) > DUTY_MAX)
            duty_clamped = DUTY_W'(DUTY_MAX);
        else
            duty_clamped = duty_i;

        // a zero count scans one digit, oversize counts scan all grids
        if (digits_i == '0)
            digits_clamped = DIG_W'(1);
        else if (int'(digits_i) > NUM_GRIDS)
            digits_clamped = DIG_W'(NUM_GRIDS);
        else
            digits_clamped = digits_i;

        cfg_d = cfg_q;
        if (rst || load) begin
            cfg_d.duty   = duty_clamped;
            cfg_d.digits = digits_clamped;
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign duty_o   = cfg_q.duty;
    assign digits_o = cfg_q.digits;

endmodule

// File: rtl/vfd_out_stage.sv
module vfd_out_stage
    import vfd_scan_pkg::*;
#(
    parameter int NUM_GRIDS  = DEF_NUM_GRIDS,
    parameter int SLOT_CLKS  = DEF_SLOT_CLKS,
    parameter int BLANK_CLKS = DEF_BLANK_CLKS,
    parameter int DUTY_W     = DEF_DUTY_W,
    localparam int SLOT_W    = $clog2(SLOT_CLKS),
    localparam int DIG_W     = $clog2(NUM_GRIDS + 1),
    localparam int ACTIVE    = SLOT_CLKS - BLANK_CLKS
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [SLOT_W-1:0]              cnt,
    input  logic [DIG_W-1:0]               dig,
    input  logic [DUTY_W-1:0]              duty,
    input  logic [1:0]                     light,
    input  logic [NUM_GRIDS*NUM_GRIDS-1:0] grid_map,
    output logic [NUM_GRIDS-1:0]           grid_o,
    output logic [DIG_W-1:0]               digit_o,
    output logic                           seg_en_o
);

    typedef struct packed {
        logic [NUM_GRIDS-1:0] grid;
        logic [DIG_W-1:0]     dig;
        logic                 seg;
    } out_t;

    out_t out_d, out_q;
    logic [NUM_GRIDS-1:0] map_row [NUM_GRIDS];
    logic [NUM_GRIDS-1:0] sel_row;
    logic                 window;
    logic                 duty_on;
    light_mode_e          mode;

    for (genvar g = 0; g < NUM_GRIDS; g++) begin : g_rows
        assign map_row[g] = grid_map[g*NUM_GRIDS +: NUM_GRIDS];
    end

    always_comb begin
        mode    = light_mode_e'(light);
        window  = (int'(cnt) < ACTIVE);
        duty_on = (int'(cnt) < int'(duty));
        sel_row = '0;
        for (int k = 0; k < NUM_GRIDS; k++) begin
            if (int'(dig) == k) sel_row = map_row[k];
        end

        out_d = out_q;
        if (rst) begin
            out_d.grid = '0;
            out_d.dig  = '0;
            out_d.seg  = 1'b0;
        end else begin
            out_d.grid = window ? sel_row : '0;
            out_d.dig  = dig;
            unique case (mode)
                LIGHT_ALL_ON, LIGHT_ALL_ON_B: out_d.seg = window;
                LIGHT_ALL_OFF:                out_d.seg = 1'b0;
                default:                      out_d.seg = window && duty_on;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign grid_o   = out_q.grid;
    assign digit_o  = out_q.dig;
    assign seg_en_o = out_q.seg;

endmodule

// File: rtl/vfd_scan_ctrl.sv
module vfd_scan_ctrl #(
    parameter int NUM_GRIDS  = vfd_scan_pkg::DEF_NUM_GRIDS,
    parameter int SLOT_CLKS  = vfd_scan_pkg::DEF_SLOT_CLKS,
    parameter int BLANK_CLKS = vfd_scan_pkg::DEF_BLANK_CLKS,
    parameter int DUTY_W     = vfd_scan_pkg::DEF_DUTY_W,
    localparam int SLOT_W    = $clog2(SLOT_CLKS),
    localparam int DIG_W     = $clog2(NUM_GRIDS + 1)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [DUTY_W-1:0]              duty_i,
    input  logic [DIG_W-1:0]               digits_i,
    input  logic [1:0]                     light_i,
    input  logic [NUM_GRIDS*NUM_GRIDS-1:0] grid_map_i,
    output logic [NUM_GRIDS-1:0]           grid_o,
    output logic [DIG_W-1:0]               digit_o,
    output logic                           seg_en_o
);

    logic [SLOT_W-1:0] cnt_w;
    logic [DIG_W-1:0]  dig_w;
    logic              frame_end_w;
    logic [DUTY_W-1:0] duty_act_w;
    logic [DIG_W-1:0]  digits_act_w;

    vfd_cfg_shadow #(
        .NUM_GRIDS (NUM_GRIDS),
        .SLOT_CLKS (SLOT_CLKS),
        .BLANK_CLKS(BLANK_CLKS),
        .DUTY_W    (DUTY_W)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .load    (frame_end_w),
        .duty_i  (duty_i),
        .digits_i(digits_i),
        .duty_o  (duty_act_w),
        .digits_o(digits_act_w)
    );

    vfd_slot_timer #(
        .NUM_GRIDS(NUM_GRIDS),
        .SLOT_CLKS(SLOT_CLKS)
    ) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .digits_act (digits_act_w),
        .cnt_o      (cnt_w),
        .dig_o      (dig_w),
        .frame_end_o(frame_end_w)
    );

    vfd_out_stage #(
        .NUM_GRIDS (NUM_GRIDS),
        .SLOT_CLKS (SLOT_CLKS),
        .BLANK_CLKS(BLANK_CLKS),
        .DUTY_W    (DUTY_W)
    ) u_out (
        .clk     (clk),
        .rst     (rst),
        .cnt     (cnt_w),
        .dig     (dig_w),
        .duty    (duty_act_w),
        .light   (light_i),
        .grid_map(grid_map_i),
        .grid_o  (grid_o),
        .digit_o (digit_o),
        .seg_en_o(seg_en_o)
    );

endmodule

// File: rtl/vfd_scan_ctrl_chk.sv
module vfd_scan_ctrl_chk #(
    parameter int NUM_GRIDS  = 24,
    parameter int SLOT_CLKS  = 1024,
    parameter int BLANK_CLKS = 64,
    parameter int DUTY_W     = 10,
    localparam int SLOT_W    = $clog2(SLOT_CLKS),
    localparam int DIG_W     = $clog2(NUM_GRIDS + 1),
    localparam int ACTIVE    = SLOT_CLKS - BLANK_CLKS
) (
    input logic                 clk,
    input logic                 rst,
    input logic [1:0]           light_i,
    input logic [NUM_GRIDS-1:0] grid_o,
    input logic [DIG_W-1:0]     digit_o,
    input logic                 seg_en_o,
    input logic [SLOT_W-1:0]    cnt_w,
    input logic [DIG_W-1:0]     dig_w,
    input logic                 frame_end_w,
    input logic [DUTY_W-1:0]    duty_act_w,
    input logic [DIG_W-1:0]     digits_act_w
);

    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (grid_o == '0) && !seg_en_o && (digit_o == '0));

    p_slot_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (int'(cnt_w) == SLOT_CLKS - 1) |=> (cnt_w == '0));

    p_blank_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (int'(cnt_w) >= ACTIVE) |=> (grid_o == '0) && !seg_en_o);

    p_duty_zero_r3: assert property (@(posedge clk) disable iff (rst)
        ((light_i == 2'b00) && (duty_act_w == '0)) |=> !seg_en_o);

    p_duty_limit_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (int'(duty_act_w) <= ACTIVE));

    p_digit_range_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (dig_w < digits_act_w));

    p_force_on_r5: assert property (@(posedge clk) disable iff (rst)
        (light_i[0] && (int'(cnt_w) < ACTIVE)) |=> seg_en_o);

    p_force_off_r5: assert property (@(posedge clk) disable iff (rst)
        (light_i == 2'b10) |=> !seg_en_o);

    p_frame_shadow_r7: assert property (@(posedge clk) disable iff (rst)
        !frame_end_w |=> $stable(duty_act_w) && $stable(digits_act_w));

    p_digit_follow_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (digit_o == $past(dig_w)));

endmodule

bind vfd_scan_ctrl vfd_scan_ctrl_chk #(
    .NUM_GRIDS (NUM_GRIDS),
    .SLOT_CLKS (SLOT_CLKS),
    .BLANK_CLKS(BLANK_CLKS),
    .DUTY_W    (DUTY_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .light_i     (light_i),
    .grid_o      (grid_o),
    .digit_o     (digit_o),
    .seg_en_o    (seg_en_o),
    .cnt_w       (cnt_w),
    .dig_w       (dig_w),
    .frame_end_w (frame_end_w),
    .duty_act_w  (duty_act_w),
    .digits_act_w(digits_act_w)
);

// File: tb/sim_vfd_scan_ctrl.sv
module sim_vfd_scan_ctrl;

    localparam int NG     = 24;
    localparam int SLOT   = 1024;
    localparam int ACTIVE = 960;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [9:0]      duty_i = '0;
    logic [4:0]      digits_i = 5'd1;
    logic [1:0]      light_i = 2'b00;
    logic [NG*NG-1:0] grid_map_i = '0;
    logic [NG-1:0]   grid_o;
    logic [4:0]      digit_o;
    logic            seg_en_o;

    int pass_n = 0;
    int total_n = 0;
    int cyc = 0;
    int m_cnt = 0;
    int m_dig = 0;
    int m_duty = 0;
    int m_digits = 1;
    bit done = 0;

    always #4 clk = ~clk;

    vfd_scan_ctrl u0 (
        .clk       (clk),
        .rst       (rst),
        .duty_i    (duty_i),
        .digits_i  (digits_i),
        .light_i   (light_i),
        .grid_map_i(grid_map_i),
        .grid_o    (grid_o),
        .digit_o   (digit_o),
        .seg_en_o  (seg_en_o)
    );

    function automatic int clamp_duty(int v);
        return (v > ACTIVE) ? ACTIVE : v;
    endfunction

    function automatic int clamp_digits(int v);
        if (v == 0) return 1;
        if (v > NG) return NG;
        return v;
    endfunction

    function automatic bit exp_seg(int p, int duty, logic [1:0] mode);
        if (p >= ACTIVE) return 1'b0;
        if (mode[0]) return 1'b1;
        if (mode == 2'b10) return 1'b0;
        return (p < duty);
    endfunction

    function automatic logic [NG-1:0] exp_grid(int p, int d, logic [NG*NG-1:0] map);
        if (p >= ACTIVE) return '0;
        return map[d*NG +: NG];
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] expv);
        total_n++;
        if (got === expv) pass_n++;
        else $display("FAIL %s: got %0h expected %0h (slot pos %0d digit %0d)",
                      req, got, expv, m_cnt, m_dig);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", pass_n, total_n);
            $finish;
        end
    endtask

    // Compare outputs with model position, then advance the model.
    task automatic run_cycles(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (m_cnt >= ACTIVE) begin
                check("R2 grid", 32'(grid_o), 32'(0));
                check("R2 seg", 32'(seg_en_o), 32'(0));
            end else begin
                check("R6 grid", 32'(grid_o), 32'(exp_grid(m_cnt, m_dig, grid_map_i)));
                check(light_i != 2'b00 ? "R5 seg" : "R3 seg",
                      32'(seg_en_o), 32'(exp_seg(m_cnt, m_duty, light_i)));
            end
            check("R1 R4 digit", 32'(digit_o), 32'(m_dig));
            // R7: shadow settings reload at the edge that ends the final slot
            if (m_cnt == SLOT - 1) begin
                m_cnt = 0;
                if (m_dig == m_digits - 1) begin
                    m_dig    = 0;
                    m_duty   = clamp_duty(int'(duty_i));
                    m_digits = clamp_digits(int'(digits_i));
                end else begin
                    m_dig++;
                end
            end else begin
                m_cnt++;
            end
        end
    endtask

    function automatic logic [NG*NG-1:0] rand_map();
        logic [NG*NG-1:0] m;
        for (int k = 0; k < NG; k++) m[k*NG +: NG] = NG'($urandom);
        return m;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            total_n++;
            $display("FAIL watchdog: got %0d cycles expected at most 190000", cyc);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < NG; k++) grid_map_i[k*NG +: NG] = NG'(1) << k;
        grid_map_i[0 +: NG] = 24'h000003;      // R6: two lines paralleled
        duty_i   = 10'd0;
        digits_i = 5'd1;
        light_i  = 2'b00;
        rst      = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        check("R9 grid", 32'(grid_o), 32'(0));
        check("R9 seg", 32'(seg_en_o), 32'(0));
        check("R9 digit", 32'(digit_o), 32'(0));
        m_duty   = clamp_duty(int'(duty_i));
        m_digits = clamp_digits(int'(digits_i));
        m_cnt = 0;
        m_dig = 0;
        rst = 1'b0;
        // R8: first edge after release shows position 0, duty 0 keeps dark (R3)
        run_cycles(2 * SLOT);

        // R3 saturation: 1000 limited to 960, two digits
        duty_i   = 10'd1000;
        digits_i = 5'd2;
        run_cycles(3 * 2 * SLOT);

        // R4: zero count scans one digit; R5 overrides
        duty_i   = 10'd500;
        digits_i = 5'd0;
        run_cycles(2 * 2 * SLOT);
        light_i = 2'b10;
        run_cycles(SLOT + 17);
        light_i = 2'b01;
        run_cycles(SLOT);
        light_i = 2'b11;
        run_cycles(SLOT);
        light_i = 2'b00;

        // R4: oversize count scans all 24 grids; R7 mid-frame write
        digits_i = 5'd30;
        duty_i   = 10'd100;
        run_cycles(3 * SLOT);
        run_cycles(12 * SLOT);
        duty_i   = 10'd700;            // R7: must wait for frame end
        digits_i = 5'd2;
        run_cycles(12 * SLOT + 3000);
        duty_i   = 10'd961;            // R7: mid-frame write in a short frame
        run_cycles(SLOT + 200);
        duty_i   = 10'd1;
        run_cycles(2 * SLOT);

        // random mix
        for (int s = 0; s < 30; s++) begin
            duty_i     = 10'($urandom);
            digits_i   = ($urandom % 4 == 0) ? 5'($urandom) : 5'($urandom % 3);
            light_i    = ($urandom % 3 == 0) ? 2'($urandom) : 2'b00;
            grid_map_i = rand_map();
            run_cycles(300 + int'($urandom % 2500));
        end

        // R9: reset mid-scan restarts at digit 0
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R9 grid", 32'(grid_o), 32'(0));
        check("R9 seg", 32'(seg_en_o), 32'(0));
        check("R9 digit", 32'(digit_o), 32'(0));
        duty_i   = 10'd5;
        digits_i = 5'd3;
        light_i  = 2'b00;
        @(negedge clk);
        m_duty   = clamp_duty(int'(duty_i));
        m_digits = clamp_digits(int'(digits_i));
        m_cnt = 0;
        m_dig = 0;
        rst = 1'b0;
        run_cycles(4 * SLOT);

        finish_run();
    end

endmodule